// File: doc/BRIEF.md
# Subcode Serial Readout Interface

This block sits after a disc demodulator and gives an external controller one subcode byte per frame. The demodulator hands over each frame byte, whose bits belong to the channels P through W, with a strobe. It also marks the two sync frames that open every 98-frame block. On each strobe the block stores the byte and pulls a frame-window output low for a fixed number of system clocks. During that window the controller pulses its own serial clock and reads the channel bits one at a time from a data pin. A separate indicator reports whether the byte on offer belongs to a sync frame.

The serial clock from the controller is asynchronous. It passes through a flop synchroniser, and each rising edge it detects moves the data pin to the next channel bit. After eight edges the sequence starts again at P. While the window is open, the block also takes the Q bit of every data frame. When the 96th data frame of a block arrives, it checks the CRC over all 96 Q bits. If the check passes, it exposes the 80 information bits.

Top module: `subq_readout`

## Requirements
- R1: While rst_n is low, win_n is 1, blksync_out, sdata_out and q_valid are 0, and q_data is all zeros.
- R2: On a clock edge where frame_stb is 1, win_n goes to 0 and stays 0 for WIN_CYCLES clock cycles, then returns to 1. A strobe that arrives while the window is open restarts the window.
- R3: frame_byte is captured only on a clock edge where frame_stb is 1. Changes on frame_byte at any other time have no effect on sdata_out.
- R4: frame_byte[7] (channel P) appears on sdata_out in the first cycle of the window. Each rising edge of sclk_in seen by the synchroniser moves sdata_out to the next bit, in the order frame_byte[7] down to frame_byte[0] (P, Q, R, S, T, U, V, W). The new bit appears after the third rising clk edge that follows the sclk_in rise.
- R5: After the eighth advance within one window, sdata_out shows frame_byte[7] again, and the sequence repeats.
- R6: blksync_out takes the value frame_sync had on the strobe edge and holds it until the next strobe.
- R7: Rising edges of sclk_in whose synchronised edge falls while win_n is 1 leave sdata_out unchanged.
- R8: The Q bit of a frame is frame_byte[6]. A strobe with frame_sync at 1 restarts Q collection. On the strobe of the 96th data frame after a restart, q_valid is set to 1 if the remainder of the 96 Q bits is zero, and to 0 otherwise. The remainder uses the generator x^16+x^12+x^5+1, a zero initial value, and the first bit entered first. q_valid changes on no other edge.
- R9: When R8 finds a zero remainder, q_data takes the first 80 Q bits of that block, with the first bit received in q_data[79]. When the remainder is not zero, q_data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle strobe marking a new frame byte |
| frame_byte | input | 8 | Channel bits of the frame, P in bit 7 down to W in bit 0 |
| frame_sync | input | 1 | High when the strobed frame is one of the two block sync frames |
| sclk_in | input | 1 | Serial read clock from the external controller, asynchronous |
| win_n | output | 1 | Frame read window, low while a read is allowed |
| blksync_out | output | 1 | High when the byte on offer belongs to a sync frame |
| sdata_out | output | 1 | Serial channel bit |
| q_valid | output | 1 | Q CRC of the last complete block passed |
| q_data | output | 80 | Q information bits of the last block that passed its CRC |

## Verification
The strobe reaches win_n, blksync_out and the first bit on sdata_out on the edge it is sampled at, so these outputs are due one cycle later. A rising edge of sclk_in needs two synchroniser flops and one advance register, so the next bit is due three clock edges after the rise. q_valid and q_data change on the strobe edge of the 96th data frame. The bench keeps a behavioural model that it updates on each rising clock edge from the same inputs, and compares every output with that model at the following falling edge. Each result is therefore checked in exactly the cycle it is due. The stimulus varies the pulse count per frame from zero to ten and places two pulses after each window. It sends one block with a correct CRC, one with a damaged CRC and then another correct block.

// File: rtl/subq_pkg.sv
package subq_pkg;
   localparam int SUBQ_BYTE_W = 8;
   localparam int SUBQ_Q_POS  = 6;
   typedef logic [SUBQ_BYTE_W-1:0] subq_byte_t;
endpackage

// File: rtl/subq_edge_sync.sv
module subq_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/subq_frame_shifter.sv
module subq_frame_shifter
   import subq_pkg::*;
#(
   parameter int WIN_CYCLES = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_stb,
   input  subq_byte_t frame_byte,
   input  logic       frame_sync,
   input  logic       adv,
   output logic       win_n,
   output logic       blksync,
   output logic       sdata
);
   localparam int CNT_W = $clog2(WIN_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYCLES - 1);

   subq_byte_t       rot_q;
   logic [CNT_W-1:0] cnt_q;
   logic             win_n_q;
   logic             sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rot_q   <= '0;
         cnt_q   <= '0;
         win_n_q <= 1'b1;
         sync_q  <= 1'b0;
      end else if (frame_stb) begin
         rot_q   <= frame_byte;
         cnt_q   <= CNT_LOAD;
         win_n_q <= 1'b0;
         sync_q  <= frame_sync;
      end else if (!win_n_q) begin
         if (adv) rot_q <= {rot_q[SUBQ_BYTE_W-2:0], rot_q[SUBQ_BYTE_W-1]};
         if (cnt_q == '0) win_n_q <= 1'b1;
         else             cnt_q   <= cnt_q - 1'b1;
      end
   end

   assign win_n   = win_n_q;
   assign blksync = sync_q;
   assign sdata   = rot_q[SUBQ_BYTE_W-1];
endmodule

// File: rtl/subq_qcrc.sv
module subq_qcrc #(
   parameter int          DATA_FRAMES = 96,
   parameter int          Q_DATA_BITS = 80,
   parameter int          CRC_W       = 16,
   parameter logic [15:0] POLY        = 16'h1021
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frame_stb,
   input  logic                   frame_sync,
   input  logic                   q_bit,
   output logic                   q_valid,
   output logic [Q_DATA_BITS-1:0] q_data
);
   localparam int CNT_W = $clog2(DATA_FRAMES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_FRAMES - 1);
   localparam logic [CRC_W-1:0] GEN  = CRC_W'(POLY);

   logic [CNT_W-1:0]       cnt_q;
   logic [CRC_W-1:0]       crc_q, crc_nx;
   logic [Q_DATA_BITS-1:0] qsh_q;
   logic                   valid_q;
   logic [Q_DATA_BITS-1:0] data_q;

   always_comb begin
      crc_nx = {crc_q[CRC_W-2:0], 1'b0};
      if (crc_q[CRC_W-1] ^ q_bit) crc_nx = crc_nx ^ GEN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         crc_q   <= '0;
         qsh_q   <= '0;
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (frame_stb) begin
         if (frame_sync) begin
            cnt_q <= '0;
            crc_q <= '0;
         end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            crc_q   <= '0;
            valid_q <= (crc_nx == '0);
            if (crc_nx == '0) data_q <= qsh_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            crc_q <= crc_nx;
            if (int'(cnt_q) < Q_DATA_BITS) qsh_q <= {qsh_q[Q_DATA_BITS-2:0], q_bit};
         end
      end
   end

   assign q_valid = valid_q;
   assign q_data  = data_q;
endmodule

// File: rtl/subq_readout.sv
module subq_readout
   import subq_pkg::*;
#(
   parameter int          WIN_CYCLES       = 64,
   parameter int          SYNC_STAGES      = 2,
   parameter int          FRAMES_PER_BLOCK = 98,
   parameter int          SYNC_FRAMES      = 2,
   parameter int          Q_DATA_BITS      = 80,
   parameter int          Q_CRC_BITS       = 16,
   parameter logic [15:0] Q_POLY           = 16'h1021
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frame_stb,
   input  logic [7:0]             frame_byte,
   input  logic                   frame_sync,
   input  logic                   sclk_in,
   output logic                   win_n,
   output logic                   blksync_out,
   output logic                   sdata_out,
   output logic                   q_valid,
   output logic [Q_DATA_BITS-1:0] q_data
);
   localparam int DATA_FRAMES = FRAMES_PER_BLOCK - SYNC_FRAMES;

   initial begin
      assert (WIN_CYCLES >= 2) else $error("WIN_CYCLES must be at least 2");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (DATA_FRAMES == Q_DATA_BITS + Q_CRC_BITS)
         else $error("data frames must equal Q data plus CRC bits");
      assert (Q_CRC_BITS >= 2 && Q_CRC_BITS <= 16) else $error("Q_CRC_BITS out of range");
   end

   logic adv;

   subq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sclk_in),
      .rise     (adv)
   );

   subq_frame_shifter #(.WIN_CYCLES(WIN_CYCLES)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_stb  (frame_stb),
      .frame_byte (frame_byte),
      .frame_sync (frame_sync),
      .adv        (adv),
      .win_n      (win_n),
      .blksync    (blksync_out),
      .sdata      (sdata_out)
   );

   subq_qcrc #(
      .DATA_FRAMES (DATA_FRAMES),
      .Q_DATA_BITS (Q_DATA_BITS),
      .CRC_W       (Q_CRC_BITS),
      .POLY        (Q_POLY)
   ) u_qcrc (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_stb  (frame_stb),
      .frame_sync (frame_sync),
      .q_bit      (frame_byte[SUBQ_Q_POS]),
      .q_valid    (q_valid),
      .q_data     (q_data)
   );
endmodule

// File: rtl/subq_readout_chk.sv
module subq_readout_chk #(
   parameter int WIN_CYCLES  = 64,
   parameter int Q_DATA_BITS = 80
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   frame_stb,
   input logic [7:0]             frame_byte,
   input logic                   frame_sync,
   input logic                   win_n,
   input logic                   blksync_out,
   input logic                   sdata_out,
   input logic                   q_valid,
   input logic [Q_DATA_BITS-1:0] q_data
);
   int low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         low_cnt <= 0;
      else if (frame_stb) low_cnt <= 0;
      else if (!win_n)    low_cnt <= low_cnt + 1;
      else                low_cnt <= 0;
   end

   // R2
   win_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> !win_n);

   // R2
   win_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_n |-> low_cnt < WIN_CYCLES);

   // R4
   p_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> sdata_out == $past(frame_byte[7]));

   // R6
   blksync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> blksync_out == $past(frame_sync));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_n && !frame_stb) |=> $stable(sdata_out));

   // R8
   qvalid_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q_valid) |-> $past(frame_stb));

   // R9
   qdata_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q_data) |-> q_valid);
endmodule

bind subq_readout subq_readout_chk #(.WIN_CYCLES(WIN_CYCLES), .Q_DATA_BITS(Q_DATA_BITS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_stb   (frame_stb),
   .frame_byte  (frame_byte),
   .frame_sync  (frame_sync),
   .win_n       (win_n),
   .blksync_out (blksync_out),
   .sdata_out   (sdata_out),
   .q_valid     (q_valid),
   .q_data      (q_data)
);

// File: tb/subq_readout_test.sv
module subq_readout_test;
   localparam int WIN = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_stb = 1'b0;
   logic [7:0]  frame_byte = 8'h00;
   logic        frame_sync = 1'b0;
   logic        sclk_in = 1'b0;
   logic        win_n, blksync_out, sdata_out, q_valid;
   logic [79:0] q_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit running = 0;

   always #5 clk = ~clk;

   subq_readout #(.WIN_CYCLES(WIN)) uut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame_byte(frame_byte),
      .frame_sync(frame_sync), .sclk_in(sclk_in), .win_n(win_n),
      .blksync_out(blksync_out), .sdata_out(sdata_out), .q_valid(q_valid), .q_data(q_data)
   );

   // behavioural reference
   bit         m_win_n = 1, m_sync = 0, m_qvalid = 0;
   bit [7:0]   m_byte = 0;
   int         m_idx = 0, m_cnt = 0;
   bit         m_s1 = 0, m_s2 = 0, m_s3 = 0;
   bit [79:0]  m_qdata = 0;
   bit         qbits[$];

   function automatic bit [15:0] remainder96(bit [95:0] msg);
      bit [95:0] r = msg;
      for (int i = 95; i >= 16; i--)
         if (r[i]) r[i -: 17] = r[i -: 17] ^ 17'h11021;
      return r[15:0];
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit rise;
         rise = m_s2 && !m_s3;
         if (frame_stb) begin
            m_byte = frame_byte; m_idx = 0; m_win_n = 0; m_cnt = WIN - 1; m_sync = frame_sync;
         end else if (!m_win_n) begin
            if (rise) m_idx = (m_idx + 1) % 8;
            if (m_cnt == 0) m_win_n = 1; else m_cnt--;
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = sclk_in;
         if (frame_stb) begin
            if (frame_sync) qbits.delete();
            else begin
               qbits.push_back(frame_byte[6]);
               if (qbits.size() == 96) begin
                  bit [95:0] msg;
                  for (int i = 0; i < 96; i++) msg[95-i] = qbits[i];
                  m_qvalid = (remainder96(msg) == 16'h0);
                  if (m_qvalid) m_qdata = msg[95:16];
                  qbits.delete();
               end
            end
         end
      end
   end

   task automatic chk(string tag, logic [79:0] act, logic [79:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (running) begin
         chk("R2 win_n", 80'(win_n), 80'(m_win_n));
         chk("R3 R4 R5 R7 sdata_out", 80'(sdata_out), 80'(m_byte[7 - m_idx]));
         chk("R6 blksync_out", 80'(blksync_out), 80'(m_sync));
         chk("R8 q_valid", 80'(q_valid), 80'(m_qvalid));
         chk("R9 q_data", q_data, m_qdata);
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   task automatic waitn(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulses(int n);
      for (int i = 0; i < n; i++) begin
         sclk_in = 1'b1; waitn(3);
         sclk_in = 1'b0; waitn(3);
      end
   endtask

   task automatic send_frame(bit sync, bit qb, int npulse);
      bit [7:0] b;
      b = 8'($urandom);
      b[6] = qb;
      frame_byte = b; frame_sync = sync; frame_stb = 1'b1;
      waitn(1);
      frame_stb = 1'b0;
      frame_byte = 8'($urandom);   // R3: changes between strobes must not matter
      frame_sync = 1'($urandom);
      pulses(npulse);
      waitn(71 - npulse * 6);
      pulses(2);                    // R7: outside the window
      waitn(36);
   endtask

   task automatic send_block(bit [79:0] data, bit corrupt);
      bit [95:0] msg;
      msg = {data, 16'h0};
      msg = {data, remainder96(msg)};
      if (corrupt) msg[3] = ~msg[3];
      for (int f = 0; f < 98; f++) begin
         if (f < 2) send_frame(1'b1, 1'($urandom), f % 11);
         else       send_frame(1'b0, msg[95 - (f - 2)], f % 11);
      end
   endtask

   initial begin
      waitn(3);
      // R1: reset values
      chk("R1 win_n", 80'(win_n), 80'(1));
      chk("R1 sdata_out", 80'(sdata_out), 80'(0));
      chk("R1 blksync_out", 80'(blksync_out), 80'(0));
      chk("R1 q_valid", 80'(q_valid), 80'(0));
      chk("R1 q_data", q_data, 80'(0));
      rst_n = 1'b1;
      running = 1;
      waitn(5);
      send_block({$urandom, $urandom, 16'($urandom)}, 1'b0);
      waitn(2);
      chk("R8 q_valid after good block", 80'(q_valid), 80'(1));
      send_block({$urandom, $urandom, 16'($urandom)}, 1'b1);
      waitn(2);
      chk("R8 q_valid after bad block", 80'(q_valid), 80'(0));
      send_block({$urandom, $urandom, 16'($urandom)}, 1'b0);
      waitn(2);
      chk("R9 q_valid after recovery", 80'(q_valid), 80'(1));
      running = 0;
      summary();
      $finish;
   end
endmodule